// File: doc/BRIEF.md
# Bloomier Exact-Match Engine

The engine watches a byte stream and reports every position where the most recent L bytes equal one of up to n stored strings. Each accepted byte completes a new window. The window is hashed by k = 4 independent functions into a lookup table of m locations. The four words read back are XORed together, and the result is a pointer into a result table of exactly n entries. The entry at that pointer is the only candidate string, and the window is compared with it in full. An equal compare produces a one-cycle match pulse that carries the pointer. A differing compare is a false positive and produces nothing.

A host fills both tables through one write port. The host also solves the lookup-table encoding, so that for every stored string the four words in its neighbourhood XOR to that string's pointer. A write interrupts scanning. Windows still in the pipeline are dropped, and the stream must supply a fresh L bytes before matching resumes.

The controller has three states. FILL counts accepted bytes after reset or after a load. It moves to SCAN on the L-th byte, and moves to LOAD on any write. SCAN checks one window for every accepted byte, and moves to LOAD on any write. LOAD holds while writes continue and returns to FILL on the first cycle without a write. The defaults are small (L = 4, n = 16, m = 64). A full-size build uses L = 32, n = 16384 and m = 65536, which gives 14-bit lookup words and 256-bit result entries.

Top module: `bmf_match_engine`

## Requirements
- R1: After reset, match_o and match_ptr are 0 and the controller is in FILL. No match is reported until L bytes have been accepted.
- R2: The window is the last L accepted bytes, with the oldest byte in the most significant byte. The result for a window appears on match_o on the 4th rising edge after the edge that accepted its last byte, and lasts one cycle.
- R3: Hash i (i = 0..3) of window x is the XOR, over every bit j that is set in x (j = 0 is the LSB), of the low log2(M_LOC) bits of floor((j+1)*(2i+1)*40503 / 32).
- R4: The candidate pointer is the XOR of the four lookup words read at the four hash addresses. When the result entry at that pointer equals the window, match_o pulses and match_ptr equals that pointer.
- R5: When the addressed result entry differs from the window, no match is reported. This holds even though a pointer was recovered.
- R6: match_ptr is 0 in every cycle in which match_o is 0.
- R7: When cfg_we = 1, cfg_sel = 0 writes the low log2(N_STR) bits of cfg_data into lookup location cfg_addr. cfg_sel = 1 writes all of cfg_data into the result entry at the low log2(N_STR) bits of cfg_addr. Later windows see the new contents.
- R8: A byte offered while cfg_we = 1, or in the LOAD cycle that follows the last write, is not accepted. Windows in flight at a write edge produce no match. After a load, L new bytes are needed before a match can be reported.
- R9: A cycle with in_valid = 0 accepts nothing and does not break the window. Bytes separated by idle cycles still form one window.
- R10: Overlapping windows are each checked, so a stored string that reappears one byte later produces matches on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_byte carries a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| cfg_we | input | 1 | Host table write strobe |
| cfg_sel | input | 1 | Table select: 0 lookup, 1 result |
| cfg_addr | input | $clog2(M_LOC) | Table address |
| cfg_data | input | 8*L_BYTES | Write data (lookup uses the low log2(N_STR) bits) |
| match_o | output | 1 | One-cycle match pulse |
| match_ptr | output | $clog2(N_STR) | Pointer of the matched string, 0 when no match |

## Verification
The bench builds the engine with L_BYTES = 4, N_STR = 16, M_LOC = 64 and four hashes. At these sizes it can solve the lookup-table encoding itself, by greedy placement, for ten stored strings, and then write every location of both tables. Because the window is four bytes and the pointer space is small, near-miss strings, filler bytes and idle gaps often recover pointers to real entries. The full compare is therefore exercised against genuine false positives. A reference model compares each window with every live string. Short repeating strings allow back-to-back overlapping matches, and they also allow writes that land while windows are still in flight.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_SCAN = 2'd1,
        ST_LOAD = 2'd2
    } eng_state_e;

    // Per-bit coefficient of one hash function; callers keep the low bits.
    function automatic logic [31:0] hash_coef(input int unsigned fn_idx,
                                              input int unsigned bit_idx);
        logic [31:0] prod;
        prod = (bit_idx + 32'd1) * (2 * fn_idx + 32'd1) * 32'd40503;
        return prod >> 5;
    endfunction

endpackage

// File: rtl/bmf_hash.sv
module bmf_hash #(
    parameter int unsigned WIN_W = 32,
    parameter int unsigned AW    = 6,
    parameter int unsigned K     = 4
) (
    input  logic             clk,
    input  logic             en,
    input  logic [WIN_W-1:0] win,
    output logic [AW-1:0]    addr_q [K]
);

    for (genvar gi = 0; gi < K; gi++) begin : g_fn
        localparam int unsigned FN = gi;
        logic [AW-1:0] acc;
        logic [31:0]   cw;

        always_comb begin
            acc = '0;
            cw  = '0;
            for (int unsigned j = 0; j < WIN_W; j++) begin
                cw = bmf_pkg::hash_coef(FN, j);
                if (win[j]) begin
                    acc = acc ^ cw[AW-1:0];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (en) begin
                addr_q[gi] <= acc;
            end
        end
    end

endmodule

// File: rtl/bmf_lut.sv
module bmf_lut #(
    parameter int unsigned M  = 64,
    parameter int unsigned Q  = 4,
    parameter int unsigned K  = 4,
    parameter int unsigned AW = $clog2(M)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [Q-1:0]  wdata,
    input  logic          rd_en,
    input  logic [AW-1:0] raddr [K],
    output logic [Q-1:0]  ptr
);

    logic [Q-1:0] mem     [M];
    logic [Q-1:0] word_q  [K];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar gp = 0; gp < K; gp++) begin : g_port
        always_ff @(posedge clk) begin
            if (rd_en) begin
                word_q[gp] <= mem[raddr[gp]];
            end
        end
    end

    always_comb begin
        ptr = '0;
        for (int unsigned i = 0; i < K; i++) begin
            ptr = ptr ^ word_q[i];
        end
    end

    // R8
    lut_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !we);

endmodule

// File: rtl/bmf_rtab.sv
module bmf_rtab #(
    parameter int unsigned N  = 16,
    parameter int unsigned W  = 32,
    parameter int unsigned PW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rd_en,
    input  logic [PW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/bmf_match_engine.sv
module bmf_match_engine
    import bmf_pkg::*;
#(
    parameter int unsigned L_BYTES = 4,
    parameter int unsigned N_STR   = 16,
    parameter int unsigned M_LOC   = 64,
    parameter int unsigned K_HASH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [7:0]                 in_byte,
    input  logic                       cfg_we,
    input  logic                       cfg_sel,
    input  logic [$clog2(M_LOC)-1:0]   cfg_addr,
    input  logic [8*L_BYTES-1:0]       cfg_data,
    output logic                       match_o,
    output logic [$clog2(N_STR)-1:0]   match_ptr
);

    localparam int unsigned WIN_W = 8 * L_BYTES;
    localparam int unsigned AW    = $clog2(M_LOC);
    localparam int unsigned PW    = $clog2(N_STR);
    localparam int unsigned FW    = $clog2(L_BYTES + 1);
    localparam logic [FW-1:0] FILL_LAST = FW'(L_BYTES - 1);

    eng_state_e        state_q, state_d;
    logic [FW-1:0]     fill_q;
    logic              take_byte, win_ok, flow;

    logic [WIN_W-1:0]  win_q, win1_q, win2_q, win3_q;
    logic              v0_q, v1_q, v2_q, v3_q;
    logic [AW-1:0]     hash_addr [K_HASH];
    logic [PW-1:0]     cand_ptr, ptr3_q;
    logic [WIN_W-1:0]  cand_str;
    logic              lut_we, rt_we, lut_rd, rt_rd;

    // ---------------- controller ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (cfg_we) begin
                    state_d = ST_LOAD;
                end else if (in_valid && fill_q == FILL_LAST) begin
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (cfg_we) begin
                    state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (!cfg_we) begin
                    state_d = ST_FILL;
                end
            end
            default: state_d = ST_FILL;
        endcase
    end

    always_comb begin
        flow      = !cfg_we;
        take_byte = in_valid && flow && (state_q != ST_LOAD);
        win_ok    = take_byte && ((state_q == ST_SCAN) || (fill_q == FILL_LAST));
        lut_we    = cfg_we && !cfg_sel;
        rt_we     = cfg_we && cfg_sel;
        lut_rd    = v1_q && flow;
        rt_rd     = v2_q && flow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (cfg_we || state_q == ST_LOAD) begin
            fill_q <= '0;
        end else if (take_byte && state_q == ST_FILL) begin
            fill_q <= fill_q + FW'(1);
        end
    end

    // ---------------- pipeline valid chain ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v0_q      <= 1'b0;
            v1_q      <= 1'b0;
            v2_q      <= 1'b0;
            v3_q      <= 1'b0;
            match_o   <= 1'b0;
            match_ptr <= '0;
        end else begin
            v0_q <= win_ok;
            v1_q <= v0_q && flow;
            v2_q <= v1_q && flow;
            v3_q <= v2_q && flow;
            if (v3_q && flow && (cand_str == win3_q)) begin
                match_o   <= 1'b1;
                match_ptr <= ptr3_q;
            end else begin
                match_o   <= 1'b0;
                match_ptr <= '0;
            end
        end
    end

    // ---------------- pipeline data ----------------
    always_ff @(posedge clk) begin
        if (take_byte) begin
            win_q <= {win_q[WIN_W-9:0], in_byte};
        end
        win1_q <= win_q;
        win2_q <= win1_q;
        win3_q <= win2_q;
        ptr3_q <= cand_ptr;
    end

    bmf_hash #(
        .WIN_W (WIN_W),
        .AW    (AW),
        .K     (K_HASH)
    ) u_hash (
        .clk    (clk),
        .en     (v0_q),
        .win    (win_q),
        .addr_q (hash_addr)
    );

    bmf_lut #(
        .M  (M_LOC),
        .Q  (PW),
        .K  (K_HASH),
        .AW (AW)
    ) u_lut (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lut_we),
        .waddr (cfg_addr),
        .wdata (cfg_data[PW-1:0]),
        .rd_en (lut_rd),
        .raddr (hash_addr),
        .ptr   (cand_ptr)
    );

    bmf_rtab #(
        .N  (N_STR),
        .W  (WIN_W),
        .PW (PW)
    ) u_rtab (
        .clk   (clk),
        .we    (rt_we),
        .waddr (cfg_addr[PW-1:0]),
        .wdata (cfg_data),
        .rd_en (rt_rd),
        .raddr (cand_ptr),
        .rdata (cand_str)
    );

    // ---------------- checks ----------------
    // R8
    load_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (state_q == ST_LOAD));

    // R8
    load_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> !v0_q);

    // R1
    fill_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && fill_q != FILL_LAST) |=> !v0_q);

    // R6
    ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_o |-> (match_ptr == '0));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(v3_q));

endmodule

// File: tb/sim_bmf_match_engine.sv
module sim_bmf_match_engine;

    localparam int L = 4, N = 16, M = 64, K = 4;
    localparam int W = 8 * L, AW = 6, PW = 4;
    localparam int HD = 5;
    localparam int N_FILL = 10;

    localparam int OP_N = 12;
    localparam int OP_KIND [OP_N] = '{4, 0, 1, 0, 2, 3, 0, 0, 1, 2, 4, 0};
    localparam int OP_ARG  [OP_N] = '{6, 1, 5, 2, 3, 4, 5, 3, 7, 1, 9, 6};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [W-1:0]  cfg_data = '0;
    logic match_o;
    logic [PW-1:0] match_ptr;

    always #10 clk = ~clk;

    bmf_match_engine #(.L_BYTES(L), .N_STR(N), .M_LOC(M), .K_HASH(K)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .match_o(match_o), .match_ptr(match_ptr)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    logic [W-1:0]  str_tab [N];
    bit            str_live [N];
    int            n_str = 0;
    logic [PW-1:0] lut_img [M];
    bit            loc_used [M];

    logic [W-1:0]  m_win = '0;
    int            m_fill = 0;
    bit            m_load = 0;
    bit            h_m [HD];
    logic [PW-1:0] h_p [HD];
    string         h_t [HD];
    logic [31:0]   lcg = 32'h1234_5678;

    // R3 hash, written from the requirement
    function automatic logic [AW-1:0] ref_hash(input int fn, input logic [W-1:0] x);
        logic [AW-1:0] a;
        logic [31:0] c;
        a = '0;
        for (int j = 0; j < W; j++) begin
            c = 32'(((j + 1) * (2 * fn + 1) * 40503) >>> 5);
            if (x[j]) a = a ^ c[AW-1:0];
        end
        return a;
    endfunction

    task automatic rnd_byte(output logic [7:0] b);
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        b = {1'b0, lcg[22:16]};
    endtask

    task automatic clear_hist();
        for (int k = 0; k < HD; k++) begin
            h_m[k] = 0; h_p[k] = '0; h_t[k] = "R1 idle";
        end
    endtask

    task automatic chk(input bit cond, input string tag, input string what);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // one clock of stimulus; checks the output due from five negedges ago
    task automatic cycle(input bit v, input logic [7:0] b, input bit we, input bit sel,
                         input logic [AW-1:0] a, input logic [W-1:0] d, input string tag);
        bit acc, em;
        logic [PW-1:0] ep;
        @(negedge clk);
        chk(match_o === h_m[HD-1] && match_ptr === h_p[HD-1], h_t[HD-1],
            $sformatf("match=%0b ptr=%0d expected match=%0b ptr=%0d",
                      match_o, match_ptr, h_m[HD-1], h_p[HD-1]));
        for (int k = HD - 1; k > 0; k--) begin
            h_m[k] = h_m[k-1]; h_p[k] = h_p[k-1]; h_t[k] = h_t[k-1];
        end
        acc = v && !we && !m_load;
        em = 0; ep = '0;
        if (we || m_load) m_fill = 0;
        if (acc) begin
            m_win = {m_win[W-9:0], b};
            if (m_fill >= L - 1) begin
                for (int s = 0; s < n_str; s++) begin
                    if (str_live[s] && str_tab[s] == m_win) begin
                        em = 1; ep = PW'(s);
                    end
                end
            end
            if (m_fill < L) m_fill++;
        end
        h_m[0] = em; h_p[0] = ep; h_t[0] = tag;
        if (we) begin
            for (int k = 1; k < HD; k++) begin
                h_m[k] = 0; h_p[k] = '0;
            end
        end
        m_load = we;
        in_valid = v; in_byte = b; cfg_we = we; cfg_sel = sel;
        cfg_addr = a; cfg_data = d;
    endtask

    task automatic feed(input logic [7:0] b, input string tag);
        cycle(1, b, 0, 0, '0, '0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(0, 8'h00, 0, 0, '0, '0, tag);
    endtask

    task automatic host_wr(input bit sel, input logic [AW-1:0] a, input logic [W-1:0] d,
                           input string tag);
        cycle(0, 8'h00, 1, sel, a, d, tag);
    endtask

    task automatic feed_word(input logic [W-1:0] w, input string tag);
        for (int i = L - 1; i >= 0; i--) feed(w[8*i +: 8], tag);
    endtask

    // greedy placement: each new string's chosen slot lies outside all earlier neighbourhoods
    task automatic build_tables();
        logic [W-1:0]  cand;
        logic [AW-1:0] h [K];
        logic [7:0]    rb;
        logic [PW-1:0] tmp;
        int ti;
        bit dup, ok;
        for (int a = 0; a < M; a++) begin lut_img[a] = '0; loc_used[a] = 0; end
        for (int s = 0; s < N; s++) begin str_tab[s] = 32'hFFFF_FFFF; str_live[s] = 0; end
        for (int t = 0; t < 400 && n_str < N_FILL; t++) begin
            if (t == 0) cand = 32'h4141_4141;
            else for (int i = 0; i < L; i++) begin rnd_byte(rb); cand[8*i +: 8] = rb; end
            dup = 0;
            for (int s = 0; s < n_str; s++) if (str_tab[s] == cand) dup = 1;
            for (int i = 0; i < K; i++) h[i] = ref_hash(i, cand);
            ti = -1;
            for (int i = 0; i < K; i++) begin
                ok = !loc_used[h[i]];
                for (int j = 0; j < K; j++) if (j != i && h[j] == h[i]) ok = 0;
                if (ok && ti < 0) ti = i;
            end
            if (!dup && ti >= 0) begin
                tmp = PW'(n_str);
                for (int j = 0; j < K; j++) if (j != ti) tmp = tmp ^ lut_img[h[j]];
                lut_img[h[ti]] = tmp;
                for (int j = 0; j < K; j++) loc_used[h[j]] = 1;
                str_tab[n_str] = cand; str_live[n_str] = 1;
                n_str++;
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0]   rb;
        logic [W-1:0] w;
        int idx;
        clear_hist();
        repeat (2) @(negedge clk);
        // R1: reset values
        chk(match_o === 1'b0 && match_ptr === '0, "R1",
            $sformatf("reset match=%0b ptr=%0d expected 0 0", match_o, match_ptr));
        rst_n = 1'b1;

        build_tables();
        chk(n_str == N_FILL, "R3", $sformatf("placed %0d strings expected %0d", n_str, N_FILL));
        for (int a = 0; a < M; a++) host_wr(0, AW'(a), W'(lut_img[a]), "R7 lookup load");
        for (int s = 0; s < N; s++) host_wr(1, AW'(s), str_tab[s], "R7 result load");
        idle(2, "R8 after load");

        // stimulus table walk
        for (int op = 0; op < OP_N; op++) begin
            idx = OP_ARG[op] % n_str;
            case (OP_KIND[op])
                0: feed_word(str_tab[idx], "R3 R4 stored string");
                1: for (int i = 0; i < OP_ARG[op]; i++) begin rnd_byte(rb); feed(rb, "R5 filler"); end
                2: begin w = str_tab[idx]; w[0] = ~w[0]; feed_word(w, "R5 near miss"); end
                3: begin
                    w = str_tab[idx];
                    feed(w[31:24], "R9 gap"); feed(w[23:16], "R9 gap");
                    idle(2, "R9 gap");
                    feed(w[15:8], "R9 gap"); feed(w[7:0], "R9 gap");
                end
                default: for (int i = 0; i < OP_ARG[op]; i++) feed(8'h41, "R10 overlap run");
            endcase
        end
        idle(6, "R2 drain");

        // R7: retire entry 1, its string must stop matching; entry 2 still matches
        str_live[1] = 0;
        host_wr(1, AW'(1), 32'hFFFF_FFFF, "R7 rewrite");
        idle(1, "R8 recovery");
        feed_word(str_tab[1], "R7 retired string");
        feed_word(str_tab[2], "R7 other entry");
        idle(5, "R7 drain");

        // R8: write lands while matches are in flight, offered bytes are dropped
        for (int i = 0; i < L; i++) feed(8'h41, "R8 before write");
        str_live[1] = 1;
        cycle(1, 8'h41, 1, 1, AW'(1), str_tab[1], "R8 in-flight kill");
        cycle(1, 8'h41, 0, 0, '0, '0, "R8 load cycle byte");
        for (int i = 0; i < L + 2; i++) feed(8'h41, "R8 refill");
        feed_word(str_tab[1], "R7 restored entry");
        idle(5, "R8 drain");

        // R1: reset in mid-stream restarts the fill
        feed(8'h41, "R1 pre reset"); feed(8'h41, "R1 pre reset");
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; cfg_we = 1'b0;
        #1;
        chk(match_o === 1'b0 && match_ptr === '0, "R1",
            $sformatf("mid reset match=%0b ptr=%0d expected 0 0", match_o, match_ptr));
        m_fill = 0; m_load = 0; clear_hist();
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < L + 1; i++) feed(8'h41, "R1 refill after reset");
        idle(6, "R1 drain");

        finish_run();
    end

endmodule